// File: doc/BRIEF.md
# Packet-Locked Stream Merge Arbiter

This block joins several streaming sources onto a single sink. Each source offers a beat made of a valid flag, a data word, a flow identifier and an end-of-packet marker. Each source gets back a ready flag. In any cycle at most one source is connected through to the sink. Every other source sees its ready flag low and keeps its beat until a later cycle.

Packets can span several beats. Once a source has had a beat without end-of-packet accepted, the merge node stays connected to that source until its end-of-packet beat is accepted. The sink therefore receives each packet as one unbroken run of beats. Between packets, a round-robin pointer chooses the next source.

A build-time mode is provided for systems that guarantee their inputs are never active together. In that mode the arbitration state is removed and the output simply follows whichever input is valid. A per-input build option marks sources that have no valid wire; such a source is treated as offering a beat on every cycle.

Top module: `stream_merge`

## Requirements
- R1: In arbitrated mode at most one bit of `in_ready` is high in any cycle. A bit of `in_ready` is high only while `out_ready` is high.
- R2: The output beat (`out_data`, `out_flow`, `out_eop`) equals the beat of the connected input in the same cycle. `out_valid` is the effective valid of that input.
- R3: After a beat with `out_eop` low is accepted, the same input stays connected until a beat with `out_eop` high is accepted from it. All other inputs see ready low during that time. Beats are neither lost nor duplicated.
- R4: When no packet is open, the connected input is the first input with an effective valid. The search starts at the pointer index and goes upward by index, wrapping from N_IN-1 to 0. When an end-of-packet beat is accepted, the pointer moves to the index after the sending input (from N_IN-1 it wraps to 0).
- R5: A first beat that has end-of-packet high is a complete one-beat packet. No lock remains after it is accepted, so the next choice follows R4.
- R6: A beat is accepted only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the lock and the pointer keep their values and the connected input does not change.
- R7: A synchronous active-high `rst` clears the lock and sets the pointer to input 0. After reset, with no input valid, `out_valid` and every `in_ready` bit are low.
- R8: An input whose bit in `VALID_PRESENT` is 0 is treated as valid in every cycle, whatever level its `in_valid` pin has.
- R9: In exclusive mode (`MODE` = exclusive) the output carries the beat of whichever input is valid. `out_valid` is the OR of the effective valids. Every `in_ready` bit equals `out_ready`. There is no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Per-input beat valid |
| in_data | input | N_IN x DATA_W | Per-input data word |
| in_flow | input | N_IN x FLOW_W | Per-input flow identifier |
| in_eop | input | N_IN | Per-input end-of-packet marker |
| in_ready | output | N_IN | Per-input ready (beat taken when valid and ready are both high) |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output data word |
| out_flow | output | FLOW_W | Output flow identifier |
| out_eop | output | 1 | Output end-of-packet marker |
| out_ready | input | 1 | Sink ready |

## Verification
Every output is a combinational function of the current inputs and the registered lock and pointer. A change at the inputs is therefore visible at the outputs in the same cycle. An accepted beat changes which input is connected from the next rising edge onward. The bench drives inputs one time unit after a rising edge and reads outputs at the following falling edge. A check on lock or pointer behaviour is placed in the cycle after the edge that accepted the deciding beat. The randomized run tracks a per-source sequence number in the data word and checks each accepted beat in the cycle it is accepted.

// File: rtl/stream_merge_pkg.sv
package stream_merge_pkg;

    typedef enum logic {
        MERGE_ARBITRATED = 1'b0,
        MERGE_EXCLUSIVE  = 1'b1
    } merge_mode_e;

    // index after idx, wrapping to zero past the last input
    function automatic int unsigned next_index(input int unsigned idx, input int unsigned count);
        return (idx + 1 >= count) ? 0 : idx + 1;
    endfunction

    function automatic int unsigned index_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/merge_rr_picker.sv
module merge_rr_picker #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  req,
    input  logic [IDX_W-1:0] base,
    output logic             found,
    output logic [IDX_W-1:0] pick_idx,
    output logic [N_IN-1:0]  pick_oh
);

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < N_IN; k++) begin
            int c;
            c = (int'(base) + k) % N_IN;
            if (!found && req[c[IDX_W-1:0]]) begin
                found    = 1'b1;
                pick_idx = c[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        pick_oh = '0;
        for (int i = 0; i < N_IN; i++) begin
            pick_oh[i] = found && (pick_idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/merge_lock_ctrl.sv
module merge_lock_ctrl
    import stream_merge_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req,
    input  logic            acc,
    input  logic            acc_eop,
    output logic [N_IN-1:0] grant
);

    logic             locked;
    logic [IDX_W-1:0] owner;
    logic [IDX_W-1:0] ptr;

    logic             found;
    logic [IDX_W-1:0] pick_idx;
    logic [N_IN-1:0]  pick_oh;
    logic [IDX_W-1:0] winner;

    merge_rr_picker #(
        .N_IN (N_IN),
        .IDX_W(IDX_W)
    ) u_picker (
        .req     (req),
        .base    (ptr),
        .found   (found),
        .pick_idx(pick_idx),
        .pick_oh (pick_oh)
    );

    assign winner = locked ? owner : pick_idx;
    assign grant  = locked ? (N_IN'(1) << owner) : pick_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            owner  <= '0;
            ptr    <= '0;
        end else if (acc) begin
            if (acc_eop) begin
                locked <= 1'b0;
                ptr    <= IDX_W'(next_index(int'(winner), N_IN));
            end else begin
                locked <= 1'b1;
                owner  <= winner;
            end
        end
    end

    // R3: an accepted mid-packet beat keeps the same input connected
    assert_lock_keeps_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && !acc_eop) |=> (grant == $past(grant)));

    // R6: without an accepted beat the lock and pointer hold
    assert_hold_without_accept_R6: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(locked) && $stable(ptr)));

    // R7: first cycle after reset starts unlocked at input 0
    assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!locked && ptr == '0));

    // R4: an accepted end-of-packet beat always releases the lock
    assert_eop_releases_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && acc_eop) |=> !locked);

endmodule

// File: rtl/merge_beat_mux.sv
module merge_beat_mux #(
    parameter int N_IN   = 4,
    parameter int BEAT_W = 21
) (
    input  logic [N_IN-1:0]             sel,
    input  logic [N_IN-1:0][BEAT_W-1:0] beats,
    output logic [BEAT_W-1:0]           beat
);

    always_comb begin
        beat = '0;
        for (int i = 0; i < N_IN; i++) begin
            beat = beat | (beats[i] & {BEAT_W{sel[i]}});
        end
    end

endmodule

// File: rtl/stream_merge.sv
module stream_merge
    import stream_merge_pkg::*;
#(
    parameter int          N_IN          = 4,
    parameter int          DATA_W        = 16,
    parameter int          FLOW_W        = 4,
    parameter merge_mode_e MODE          = MERGE_ARBITRATED,
    parameter logic [N_IN-1:0] VALID_PRESENT = '1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_IN-1:0]             in_valid,
    input  logic [N_IN-1:0][DATA_W-1:0] in_data,
    input  logic [N_IN-1:0][FLOW_W-1:0] in_flow,
    input  logic [N_IN-1:0]             in_eop,
    output logic [N_IN-1:0]             in_ready,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic [FLOW_W-1:0]           out_flow,
    output logic                        out_eop,
    input  logic                        out_ready
);

    localparam int IDX_W = index_width(N_IN);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLOW_W-1:0] flow;
        logic              eop;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    logic [N_IN-1:0]             eff_valid;
    logic [N_IN-1:0][BEAT_W-1:0] beats;
    logic [N_IN-1:0]             sel;
    logic [BEAT_W-1:0]           mux_out;
    beat_t                       out_beat;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        if (VALID_PRESENT[i]) begin : g_has_valid
            assign eff_valid[i] = in_valid[i];
        end else begin : g_always_valid
            assign eff_valid[i] = 1'b1;
        end
        assign beats[i] = {in_data[i], in_flow[i], in_eop[i]};
    end

    merge_beat_mux #(
        .N_IN  (N_IN),
        .BEAT_W(BEAT_W)
    ) u_mux (
        .sel  (sel),
        .beats(beats),
        .beat (mux_out)
    );

    assign out_beat = beat_t'(mux_out);
    assign out_data = out_beat.data;
    assign out_flow = out_beat.flow;
    assign out_eop  = out_beat.eop;

    if (MODE == MERGE_EXCLUSIVE) begin : g_exclusive
        assign sel       = eff_valid;
        assign out_valid = |eff_valid;
        assign in_ready  = {N_IN{out_ready}};

        // R9: exclusive mode relies on no two inputs being valid together
        assert_excl_onehot_R9: assert property (@(posedge clk) disable iff (rst)
            $onehot0(eff_valid));
    end else begin : g_arbitrated
        logic [N_IN-1:0] grant;
        logic            acc;

        assign acc = out_valid && out_ready;

        merge_lock_ctrl #(
            .N_IN (N_IN),
            .IDX_W(IDX_W)
        ) u_lock (
            .clk    (clk),
            .rst    (rst),
            .req    (eff_valid),
            .acc    (acc),
            .acc_eop(out_beat.eop),
            .grant  (grant)
        );

        assign sel       = grant;
        assign out_valid = |(grant & eff_valid);
        assign in_ready  = grant & {N_IN{out_ready}};

        // R1: never more than one source sees ready
        assert_single_ready_R1: assert property (@(posedge clk) disable iff (rst)
            $onehot0(in_ready));

        // R2: a ready source is the one whose beat is on the output
        assert_ready_source_valid_R2: assert property (@(posedge clk) disable iff (rst)
            (|(in_ready & eff_valid)) |-> out_valid);
    end

    // R1: no ready reaches any source while the sink stalls
    assert_stall_blocks_ready_R1: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> (in_ready == '0));

endmodule

// File: tb/test_stream_merge.sv
module test_stream_merge;
    import stream_merge_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // main arbitrated instance: 4 inputs
    logic [3:0]       v, rdy, e;
    logic [3:0][15:0] d;
    logic [3:0][3:0]  f;
    logic             ov, oe, ord;
    logic [15:0]      od;
    logic [3:0]       of;

    stream_merge #(.N_IN(4), .DATA_W(16), .FLOW_W(4)) i_stream_merge (
        .clk(clk), .rst(rst), .in_valid(v), .in_data(d), .in_flow(f), .in_eop(e),
        .in_ready(rdy), .out_valid(ov), .out_data(od), .out_flow(of), .out_eop(oe),
        .out_ready(ord));

    // exclusive instance: 3 inputs
    logic [2:0]       xv, xrdy, xe;
    logic [2:0][15:0] xd;
    logic [2:0][3:0]  xf;
    logic             xov, xoe, xord;
    logic [15:0]      xod;
    logic [3:0]       xof;

    stream_merge #(.N_IN(3), .DATA_W(16), .FLOW_W(4), .MODE(MERGE_EXCLUSIVE)) i_stream_merge_excl (
        .clk(clk), .rst(rst), .in_valid(xv), .in_data(xd), .in_flow(xf), .in_eop(xe),
        .in_ready(xrdy), .out_valid(xov), .out_data(xod), .out_flow(xof), .out_eop(xoe),
        .out_ready(xord));

    // instance where input 1 has no valid wire
    logic [1:0]       nv, nrdy, ne;
    logic [1:0][15:0] nd;
    logic [1:0][3:0]  nf;
    logic             nov, noe, nord;
    logic [15:0]      nod;
    logic [3:0]       nof;

    stream_merge #(.N_IN(2), .DATA_W(16), .FLOW_W(4), .VALID_PRESENT(2'b01)) i_stream_merge_nv (
        .clk(clk), .rst(rst), .in_valid(nv), .in_data(nd), .in_flow(nf), .in_eop(ne),
        .in_ready(nrdy), .out_valid(nov), .out_data(nod), .out_flow(nof), .out_eop(noe),
        .out_ready(nord));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic quiet();
        v = '0; e = '0; ord = 1'b1;
        for (int i = 0; i < 4; i++) begin
            d[i] = 16'(16'h100 + i);
            f[i] = 4'(8 + i);
        end
        xv = '0; xe = '0; xord = 1'b1;
        nv = '0; ne = '0; nord = 1'b1;
        for (int i = 0; i < 3; i++) begin
            xd[i] = 16'(16'h300 + i);
            xf[i] = 4'(i + 1);
        end
        for (int i = 0; i < 2; i++) begin
            nd[i] = 16'(16'h500 + i);
            nf[i] = 4'(i + 4);
        end
    endtask

    task automatic do_reset();
        quiet();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    // R7 reset state, then R4/R5/R2 rotation over single-beat packets
    task automatic t_reset_and_rotation();
        do_reset();
        settle();
        chk(ov == 1'b0, "R7 out_valid idle after reset", int'(ov), 0);
        chk(rdy == 4'b0000, "R7 no ready after reset", int'(rdy), 0);
        step();
        v = 4'b1111; e = 4'b1111;
        settle();
        chk(rdy == 4'b0001, "R7 pointer starts at input 0", int'(rdy), 1);
        chk(od == 16'h100 && of == 4'd8 && oe, "R2 output beat of input 0", int'(od), 'h100);
        for (int k = 1; k <= 5; k++) begin
            step();
            settle();
            chk(rdy == 4'(1 << (k % 4)), "R4 round-robin order", int'(rdy), 1 << (k % 4));
            chk(od == 16'(16'h100 + k % 4) && of == 4'(8 + k % 4),
                "R2 output follows winner", int'(od), 'h100 + k % 4);
        end
    endtask

    // R3 lock across a three-beat packet, then R4 wrap of the pointer
    task automatic t_packet_lock();
        do_reset();
        v = 4'b0100; e = 4'b0000; d[2] = 16'h200;
        settle();
        chk(rdy == 4'b0100, "R3 lone requester connected", int'(rdy), 4);
        step();
        v = 4'b0111; d[2] = 16'h201;
        settle();
        chk(rdy == 4'b0100, "R3 lock holds beat 2", int'(rdy), 4);
        chk(od == 16'h201, "R3 beat 2 data", int'(od), 'h201);
        step();
        d[2] = 16'h202; e[2] = 1'b1;
        settle();
        chk(rdy == 4'b0100 && oe, "R3 lock holds end beat", int'(rdy), 4);
        step();
        v = 4'b0011; e = 4'b0000;
        settle();
        chk(rdy == 4'b0001, "R4 pointer wraps past input 3", int'(rdy), 1);
    endtask

    // R6 sink stall during a lock and between packets
    task automatic t_backpressure();
        // continues from t_packet_lock: input 0 connected, eop low
        step();
        ord = 1'b0;
        for (int k = 0; k < 3; k++) begin
            settle();
            chk(rdy == 4'b0000 && ov, "R6 stall: valid shown, no ready", int'(rdy), 0);
            chk(od == d[0], "R6 stall keeps locked beat", int'(od), int'(d[0]));
            step();
        end
        ord = 1'b1;
        settle();
        chk(rdy == 4'b0001, "R6 lock survives stall", int'(rdy), 1);
        e[0] = 1'b1;
        step();
        v = 4'b0101; e = 4'b1111; ord = 1'b0;
        step();
        settle();
        chk(ov && od == d[2] && rdy == 4'b0000, "R6 unlocked stall shows input 2", int'(od), int'(d[2]));
        step();
        ord = 1'b1;
        settle();
        chk(rdy == 4'b0100, "R6 pointer unchanged by stall", int'(rdy), 4);
    endtask

    // R5 one-beat packet releases immediately
    task automatic t_single_beat();
        do_reset();
        v = 4'b0001; e = 4'b0001;
        step();
        v = 4'b0011; e = 4'b0011;
        settle();
        chk(rdy == 4'b0010, "R5 no lock after one-beat packet", int'(rdy), 2);
    endtask

    // R8 input without a valid wire
    task automatic t_no_valid_wire();
        do_reset();
        settle();
        chk(nov == 1'b1, "R8 missing valid counts as valid", int'(nov), 1);
        chk(nrdy == 2'b10 && nod == 16'h501 && nof == 4'd5, "R8 beat from always-valid input",
            int'(nod), 'h501);
    endtask

    // R9 exclusive mode
    task automatic t_exclusive();
        do_reset();
        settle();
        chk(xov == 1'b0, "R9 no valid input gives no output", int'(xov), 0);
        step();
        xv = 3'b010; xe = 3'b010;
        settle();
        chk(xov && xod == 16'h301 && xof == 4'd2 && xoe, "R9 forwards input 1", int'(xod), 'h301);
        chk(xrdy == 3'b111, "R9 ready follows sink", int'(xrdy), 7);
        step();
        xv = 3'b100; xe = 3'b000; xord = 1'b0;
        settle();
        chk(xov && xod == 16'h302 && !xoe, "R9 forwards input 2", int'(xod), 'h302);
        chk(xrdy == 3'b000, "R9 ready low on stall", int'(xrdy), 0);
    endtask

    // R3/R2 randomized packets with sink backpressure
    task automatic t_random();
        localparam int TARGET = 60;
        int  sent[4], rem[4], rx[4];
        bit  acc[4];
        bit  in_pkt;
        int  pkt_src;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            sent[i] = 0; rem[i] = 0; rx[i] = 0; acc[i] = 0;
        end
        in_pkt = 0; pkt_src = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            bit done;
            done = 1;
            for (int i = 0; i < 4; i++) begin
                if (acc[i]) begin
                    sent[i]++; rem[i]--;
                    v[i] = 1'b0;
                end
                if (rem[i] > 0) v[i] = 1'b1;
                else if (sent[i] < TARGET && ($urandom % 2) == 0) begin
                    rem[i] = 1 + int'($urandom % 4);
                    if (rem[i] > TARGET - sent[i]) rem[i] = TARGET - sent[i];
                    v[i] = 1'b1;
                end
                d[i] = {2'(i), 14'(sent[i])};
                f[i] = 4'(i);
                e[i] = (rem[i] == 1);
                if (sent[i] < TARGET) done = 0;
            end
            ord = (($urandom % 4) != 0);
            if (done) break;
            settle();
            for (int i = 0; i < 4; i++) acc[i] = v[i] && rdy[i];
            if (ov && ord) begin
                int src;
                src = int'(od[15:14]);
                chk(int'(of) == src && acc[src], "R2 flow and ready match beat", int'(of), src);
                chk(int'(od[13:0]) == rx[src], "R3 beat order per source", int'(od[13:0]), rx[src]);
                chk(!in_pkt || src == pkt_src, "R3 packet not interleaved", src, pkt_src);
                rx[src]++;
                in_pkt  = !oe;
                pkt_src = src;
            end
            step();
        end
        for (int i = 0; i < 4; i++)
            chk(rx[i] == TARGET, "R3 no beat lost", rx[i], TARGET);
    endtask

    initial begin
        quiet();
        t_reset_and_rotation();
        t_packet_lock();
        t_backpressure();
        t_single_beat();
        t_no_valid_wire();
        t_exclusive();
        t_random();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule